// File: doc/BRIEF.md
# Multi-word register fill tracker

This block watches a bank of software-writable words, such as a key or an initialisation vector, that software loads one word per bus write. It does not hold the data. It only watches the per-word write strobes and reports whether the bank holds a complete value that nobody has consumed yet ("fresh"), and whether the bank is free of a half-finished rewrite ("clean"). A one-cycle pulse marks each moment the fresh flag rises, so a neighbour can, for example, ask for a reseed whenever a key has been fully replaced.

A consumer drives three strobes. Use means the value was consumed: it is no longer fresh, but it stays clean. Arm means the value stays fresh while the consumer works on it, and any rewrite that follows must be complete. Clear drops all history, and the consumer issues it whenever the configuration changes. Each word strobe fans out to `SLICES_PER_WORD` tracked slices, so a bank that an internal updater writes in narrower slices can share the same tracker.

Top module: `regbank_fill_tracker`

## Requirements
- R1: `fresh_o` rises only after every word has been written at least once since the last clear, use, arm or completion. Whenever `fresh_o` is high, `clean_o` is also high.
- R2: `clean_o` is high when a complete value has been seen since the last clear and no partial rewrite is pending. Before any completion, or after a write to some but not all words of a new round, `clean_o` is low. Such a partial write also drops `fresh_o`.
- R3: `use_i` drops `fresh_o`, discards any partial progress and keeps the completion history, so a previously complete bank reads clean. Word writes in the same cycle are ignored.
- R4: `arm_i` keeps `fresh_o` at its value and discards partial progress. Word writes in the same cycle are ignored. A later write to only some words drops both `fresh_o` and `clean_o`.
- R5: `clear_i` drops `fresh_o`, `clean_o` and the completion history, and ignores word writes in the same cycle. Clear wins over use, and use wins over arm.
- R6: `fresh_pulse_o` is high for exactly the first cycle in which `fresh_o` is high. A completion while `fresh_o` is already high gives no pulse.
- R7: Writing the same word again does not advance completion. Completion needs each distinct word.
- R8: Bit k of `word_we_i` marks word k. All NUM_WORDS words, in any order or all in one cycle, complete the bank.
- R9: While `rst_ni` is low all outputs are low and the bank counts as never written. Reset is released synchronously through two flops.
- R10: Outputs are registered. They reflect the strobes sampled on a rising clock edge right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_we_i | input | NUM_WORDS | Per-word write strobe, bit k for word k |
| use_i | input | 1 | Value consumed |
| clear_i | input | 1 | Drop all tracking |
| arm_i | input | 1 | Keep value fresh and guard against partial rewrite |
| fresh_o | output | 1 | Complete, unconsumed value present |
| fresh_pulse_o | output | 1 | One-cycle pulse when fresh_o rises |
| clean_o | output | 1 | Bank holds no partial rewrite and has a complete value in its history |

## Verification
The collisions that matter are a word write landing in the same cycle as a use, an arm or a clear, and the three control strobes landing together. The bench drives these combinations deliberately: a write with use, a write with arm, and clear with use, arm and a write all at once. A behavioural model, with its own per-word flags and plain priority rules, predicts all three outputs and is compared with the design after every clock edge. The case where a completion coincides with an already-fresh value is also provoked, to confirm that no second pulse appears.

// File: rtl/regbank_fill_pkg.sv
package regbank_fill_pkg;
  // Resolved control action for one cycle, after priority.
  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_ARM   = 2'd1,
    TRK_USE   = 2'd2,
    TRK_CLEAR = 2'd3
  } trk_cmd_e;
endpackage

// File: rtl/trk_cmd_decode.sv
module trk_cmd_decode
  import regbank_fill_pkg::*;
(
  input  logic     use_i,
  input  logic     clear_i,
  input  logic     arm_i,
  output trk_cmd_e cmd_o
);
  // Priority: clear over use over arm.
  always_comb begin
    if (clear_i)    cmd_o = TRK_CLEAR;
    else if (use_i) cmd_o = TRK_USE;
    else if (arm_i) cmd_o = TRK_ARM;
    else            cmd_o = TRK_IDLE;
  end
endmodule

// File: rtl/trk_slice_accum.sv
module trk_slice_accum
  import regbank_fill_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] we_i,
  input  trk_cmd_e         cmd_i,
  output logic             full_hit_o,
  output logic             partial_hit_o,
  output logic             pending_o
);
  logic [WIDTH-1:0] seen_q, seen_d, acc;

  assign acc = seen_q | we_i;

  always_comb begin
    seen_d        = seen_q;
    full_hit_o    = 1'b0;
    partial_hit_o = 1'b0;
    if (cmd_i != TRK_IDLE) begin
      seen_d = '0;
    end else if (&acc) begin
      seen_d     = '0;
      full_hit_o = 1'b1;
    end else begin
      seen_d        = acc;
      partial_hit_o = |we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= seen_d;
  end

  assign pending_o = |seen_q;

  // A completion and a partial write are exclusive.
  AST_HIT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_hit_o && partial_hit_o)); // R7
  // A control strobe leaves no partial progress behind.
  AST_CMD_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != TRK_IDLE) |=> !pending_o); // R3
endmodule

// File: rtl/trk_status_flags.sv
module trk_status_flags
  import regbank_fill_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  trk_cmd_e cmd_i,
  input  logic     full_hit_i,
  input  logic     partial_hit_i,
  input  logic     pending_i,
  output logic     fresh_o,
  output logic     pulse_o,
  output logic     clean_o
);
  logic hist_q, hist_d;
  logic fresh_q, fresh_d;
  logic fresh_dly_q;

  always_comb begin
    hist_d  = hist_q;
    fresh_d = fresh_q;
    unique case (cmd_i)
      TRK_CLEAR: begin
        hist_d  = 1'b0;
        fresh_d = 1'b0;
      end
      TRK_USE:  fresh_d = 1'b0;
      TRK_ARM:  fresh_d = fresh_q;
      default: begin
        if (full_hit_i) begin
          hist_d  = 1'b1;
          fresh_d = 1'b1;
        end else if (partial_hit_i) begin
          fresh_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q      <= 1'b0;
      fresh_q     <= 1'b0;
      fresh_dly_q <= 1'b0;
    end else begin
      hist_q      <= hist_d;
      fresh_q     <= fresh_d;
      fresh_dly_q <= fresh_q;
    end
  end

  assign fresh_o = fresh_q;
  assign pulse_o = fresh_q & ~fresh_dly_q;
  assign clean_o = hist_q & ~pending_i;

  AST_FRESH_IS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh_o |-> clean_o); // R1
  AST_PULSE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $rose(fresh_q)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R6
  AST_ARM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == TRK_ARM) |=> $stable(fresh_q)); // R4
endmodule

// File: rtl/regbank_fill_tracker.sv
module regbank_fill_tracker
  import regbank_fill_pkg::*;
#(
  parameter int NUM_WORDS       = 4,
  parameter int SLICES_PER_WORD = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WORDS-1:0] word_we_i,
  input  logic                 use_i,
  input  logic                 clear_i,
  input  logic                 arm_i,
  output logic                 fresh_o,
  output logic                 fresh_pulse_o,
  output logic                 clean_o
);
  localparam int NumSlices = NUM_WORDS * SLICES_PER_WORD;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // Fan each word strobe out to its slices.
  logic [NumSlices-1:0] slice_we;
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar s = 0; s < SLICES_PER_WORD; s++) begin : g_slice
      assign slice_we[w*SLICES_PER_WORD + s] = word_we_i[w];
    end
  end

  trk_cmd_e cmd;
  logic     full_hit, partial_hit, pending;

  trk_cmd_decode u_decode (
    .use_i   (use_i),
    .clear_i (clear_i),
    .arm_i   (arm_i),
    .cmd_o   (cmd)
  );

  trk_slice_accum #(.WIDTH(NumSlices)) u_accum (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .we_i          (slice_we),
    .cmd_i         (cmd),
    .full_hit_o    (full_hit),
    .partial_hit_o (partial_hit),
    .pending_o     (pending)
  );

  trk_status_flags u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .cmd_i         (cmd),
    .full_hit_i    (full_hit),
    .partial_hit_i (partial_hit),
    .pending_i     (pending),
    .fresh_o       (fresh_o),
    .pulse_o       (fresh_pulse_o),
    .clean_o       (clean_o)
  );

  AST_CLEAR_WIPES: assert property (@(posedge clk_i) disable iff (!rst_n)
    clear_i |=> (!fresh_o && !clean_o)); // R5
  AST_USE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (use_i && !clear_i) |=> !fresh_o); // R3
  AST_USE_KEEPS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (use_i && !clear_i && clean_o) |=> clean_o); // R3
  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_n |-> (!fresh_o && !clean_o && !fresh_pulse_o)); // R9
endmodule

// File: tb/tb_regbank_fill_tracker.sv
`timescale 1ns/1ps
module tb_regbank_fill_tracker;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [NW-1:0] word_we;
  logic          use_s, clr_s, arm_s;
  logic          fresh, pulse, clean;

  int    total = 0;
  int    bad = 0;
  string req = "R9";

  // Behavioural model state
  bit m_written [NW];
  bit m_hist, m_fresh, m_pulse;

  always #2 clk = ~clk;

  regbank_fill_tracker #(.NUM_WORDS(NW), .SLICES_PER_WORD(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_we_i(word_we), .use_i(use_s),
    .clear_i(clr_s), .arm_i(arm_s), .fresh_o(fresh),
    .fresh_pulse_o(pulse), .clean_o(clean)
  );

  function automatic bit m_any();
    for (int i = 0; i < NW; i++) if (m_written[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_step(input logic [NW-1:0] we, input bit u, input bit c, input bit a);
    bit was = m_fresh;
    bit all;
    if (c) begin
      for (int i = 0; i < NW; i++) m_written[i] = 0;
      m_hist = 0; m_fresh = 0;
    end else if (u) begin
      for (int i = 0; i < NW; i++) m_written[i] = 0;
      m_fresh = 0;
    end else if (a) begin
      for (int i = 0; i < NW; i++) m_written[i] = 0;
    end else if (we != 0) begin
      all = 1;
      for (int i = 0; i < NW; i++) begin
        if (we[i]) m_written[i] = 1;
        if (!m_written[i]) all = 0;
      end
      if (all) begin
        for (int i = 0; i < NW; i++) m_written[i] = 0;
        m_hist = 1; m_fresh = 1;
      end else begin
        m_fresh = 0;
      end
    end
    m_pulse = m_fresh & ~was;
  endtask

  task automatic compare();
    bit m_clean = m_hist & ~m_any();
    total++;
    if (fresh !== m_fresh || pulse !== m_pulse || clean !== m_clean) begin
      bad++;
      $display("FAIL %s: fresh/pulse/clean actual=%b%b%b expected=%b%b%b at %0t",
               req, fresh, pulse, clean, m_fresh, m_pulse, m_clean, $time);
    end
  endtask

  task automatic cyc(input logic [NW-1:0] we, input bit u = 0, input bit c = 0, input bit a = 0);
    @(negedge clk);
    word_we = we; use_s = u; clr_s = c; arm_s = a;
    @(posedge clk);
    #1;
    model_step(we, u, c, a);
    compare();
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; word_we = '0; use_s = 0; clr_s = 0; arm_s = 0;
    m_hist = 0; m_fresh = 0; m_pulse = 0;
    for (int i = 0; i < NW; i++) m_written[i] = 0;
    // R9: reset state, with strobes driven during reset having no effect
    repeat (2) @(negedge clk);
    word_we = '1;
    @(negedge clk); #1; compare();
    word_we = '0;
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) cyc('0);

    // R8 R1 R6 R10: one word per cycle
    req = "R1";
    cyc(4'b0001); cyc(4'b0010); cyc(4'b0100);
    req = "R6"; cyc(4'b1000); cyc('0);
    // R3: use, then use with a concurrent write
    req = "R3";
    cyc('0, 1); cyc(4'b1111, 1); cyc('0);
    // R2: partial rewrite after a complete value, then finish it
    req = "R2";
    cyc(4'b0010); cyc(4'b0001); cyc(4'b0100);
    req = "R1"; cyc(4'b1000);
    req = "R3"; cyc('0, 1);
    // R7: repeated word writes do not complete
    req = "R7";
    cyc(4'b0001); cyc(4'b0001); cyc(4'b0001); cyc(4'b0011); cyc(4'b0110);
    cyc(4'b1000);
    // R6: completion while already fresh gives no pulse
    req = "R6";
    cyc(4'b1111); cyc('0);
    // R4: arm with concurrent write, fresh held; partial write afterwards
    req = "R4";
    cyc(4'b1111, 0, 0, 1); cyc('0); cyc(4'b0100); cyc('0);
    req = "R8"; cyc(4'b1011);
    // R5: clear with use, arm and write together
    req = "R5";
    cyc(4'b1111, 1, 1, 1); cyc('0); cyc(4'b0010); cyc('0, 1); cyc('0);
    // R5: use beats arm
    cyc(4'b1111); cyc('0, 1, 0, 1); cyc('0);
    // R4: arm while not fresh keeps it low
    req = "R4";
    cyc(4'b0101); cyc('0, 0, 0, 1); cyc(4'b1010); cyc('0);
    // R8: all words in one cycle after clear
    req = "R8";
    cyc('0, 0, 1); cyc(4'b1111); cyc('0);
    // R9: reset mid-run returns all flags low
    req = "R9";
    @(negedge clk); rst_ni = 1'b0;
    m_hist = 0; m_fresh = 0; m_pulse = 0;
    for (int i = 0; i < NW; i++) m_written[i] = 0;
    #1; compare();
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) cyc('0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule